// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block connects a synchronous request port to an external asynchronous static RAM of 32768 bytes. The SRAM has active-low select, write and output strobes, a 15-bit address and a shared 8-bit data bus. A requester presents a read or a write while the block reports itself ready. The block then runs the strobe sequence on the memory pins and signals completion with a one-cycle done pulse. Read data comes back on a held output.

All strobe intervals come from minimum times given as parameters in nanoseconds. Each time is turned into a whole number of clock cycles by rounding up against the clock period parameter. A read keeps the select and output strobes low for the longest of the address access, output-enable access and read cycle times. A write keeps select and write low together, with output enable high, for the longest of the write pulse, address-to-end, select-to-end and data setup times. After a read the block waits for the memory's output release time before it can drive the bus again.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is high and in the first idle cycle after it, all three strobes are high (inactive), `req_ready` is 1, `done` is 0 and `rd_data` is 0.
- R2: A request (`req_valid` high) is taken only at a clock edge where `req_ready` is 1. A request raised while the block is busy has no effect on memory and produces no done pulse.
- R3: A write holds `sram_ce_n` and `sram_we_n` low together, with `sram_oe_n` high, for ceil(max(write pulse, address-to-end, select-to-end, data setup) / clock) cycles: 5 cycles at the defaults. Address and data stay constant through that window, and the written byte lands at the requested address.
- R4: A read holds `sram_ce_n` and `sram_oe_n` low with `sram_we_n` high for ceil(max(address access, output-enable access, read cycle) / clock) cycles: 6 at the defaults. The bus value on the last of those cycles is returned on `rd_data`.
- R5: The block drives `sram_dq` only while its write strobe is active, and leaves the bus released at all other times.
- R6: After a read ends, the write strobe stays high for at least the output release time (20 ns by default). The memory's outputs and the block's drivers are therefore never on together.
- R7: `done` is a single-cycle pulse. Counted in cycles from the accepting edge, it first shows high 8 cycles later for a read (6 access + 2 turnaround) and 6 cycles later for a write (5 strobe + 1 recovery) at the defaults. A new request may be accepted in the cycle `done` is high.
- R8: `rd_data` keeps its value until the next read completes. Writes do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address of the request |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Block is idle and takes a request this edge |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Data from the most recent read |
| sram_addr | output | 15 | Memory address pins |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_dq | inout | 8 | Bidirectional memory data bus |

## Verification
The bench builds the block with the default 10 ns clock and the fast-grade timings. This gives phases of 6 read cycles, 2 turnaround cycles, 5 write cycles and 1 recovery cycle. Its memory model delays valid read data by the full address access time and keeps driving the bus for the release time after output enable rises. A capture that comes too early, or a write that starts too soon after a read, shows up at the pins. The vectors cover both ends of the address range, an overwrite, an unwritten location and a read directly followed by a write.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

    // Access sequencer phases
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,      // select + output enable low
        ST_GAP,     // bus release after a read
        ST_WR,      // select + write low, bus driven
        ST_REC      // strobes high after a write
    } seq_state_t;

    // Round a nanosecond figure up to whole clock cycles
    function automatic int ns_to_cyc(input int t_ns, input int clk_ns);
        return (t_ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int at_least_one(input int a);
        return (a < 1) ? 1 : a;
    endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
`timescale 1ns/1ps
module sram_ctrl_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // R7: without a load the phase counter never climbs
    a_r7_no_count_up: assert property (@(posedge clk) disable iff (rst)
        !load |=> cnt <= $past(cnt));

endmodule

// File: rtl/sram_ctrl_fsm.sv
`timescale 1ns/1ps
module sram_ctrl_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int RD_LEN  = 6,
    parameter int GAP_LEN = 2,
    parameter int WR_LEN  = 5,
    parameter int REC_LEN = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic req_write,
    output logic accept,
    output logic ready,
    output logic cap_rd,
    output logic done,
    output logic ce_n,
    output logic we_n,
    output logic oe_n,
    output logic dq_oe
);
    localparam int MAX_LEN = imax(imax(RD_LEN, GAP_LEN), imax(WR_LEN, REC_LEN));
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    seq_state_t       state, nxt;
    logic             t_load, t_zero;
    logic [CNT_W-1:0] t_val;

    sram_ctrl_timer #(.CNT_W(CNT_W)) timer_i (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .zero     (t_zero)
    );

    assign ready  = (state == ST_IDLE);
    assign accept = ready && req_valid;
    assign cap_rd = (state == ST_RD) && t_zero;

    always_comb begin
        nxt    = state;
        t_load = 1'b0;
        t_val  = '0;
        case (state)
            ST_IDLE: if (req_valid) begin
                t_load = 1'b1;
                if (req_write) begin
                    nxt   = ST_WR;
                    t_val = CNT_W'(WR_LEN - 1);
                end else begin
                    nxt   = ST_RD;
                    t_val = CNT_W'(RD_LEN - 1);
                end
            end
            ST_RD: if (t_zero) begin
                nxt    = ST_GAP;
                t_load = 1'b1;
                t_val  = CNT_W'(GAP_LEN - 1);
            end
            ST_WR: if (t_zero) begin
                nxt    = ST_REC;
                t_load = 1'b1;
                t_val  = CNT_W'(REC_LEN - 1);
            end
            ST_GAP, ST_REC: if (t_zero) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // Pin strobes registered from the next phase so they change cleanly on an edge
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            ce_n  <= 1'b1;
            we_n  <= 1'b1;
            oe_n  <= 1'b1;
            dq_oe <= 1'b0;
            done  <= 1'b0;
        end else begin
            state <= nxt;
            ce_n  <= !((nxt == ST_RD) || (nxt == ST_WR));
            we_n  <= (nxt != ST_WR);
            oe_n  <= (nxt != ST_RD);
            dq_oe <= (nxt == ST_WR);
            done  <= ((state == ST_GAP) || (state == ST_REC)) && t_zero;
        end
    end

    // R7: completion is a single-cycle pulse
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2: the sequencer only leaves idle because a request was present
    a_r2_leave_on_request: assert property (@(posedge clk) disable iff (rst)
        $fell(ready) |-> $past(req_valid));

endmodule

// File: rtl/sram_ctrl_io.sv
`timescale 1ns/1ps
module sram_ctrl_io #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              cap_rd,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rd_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rd_data <= '0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (cap_rd)
                rd_data <= dq_in;
        end
    end

    // R8: returned data moves only on a read capture
    a_r8_rd_data_held: assert property (@(posedge clk) disable iff (rst)
        !cap_rd |=> $stable(rd_data));

endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W     = 15,
    parameter int DATA_W     = 8,
    parameter int T_CLK_NS   = 10,
    parameter int T_AA_NS    = 55,  // address to valid data
    parameter int T_DOE_NS   = 25,  // output enable to valid data
    parameter int T_RC_NS    = 55,  // read cycle
    parameter int T_HZOE_NS  = 20,  // output enable high to bus released
    parameter int T_PWE_NS   = 40,  // write strobe width
    parameter int T_AW_NS    = 45,  // address setup to write end
    parameter int T_SCE_NS   = 45,  // select low to write end
    parameter int T_SD_NS    = 25,  // data setup to write end
    parameter int T_HD_NS    = 0,   // data hold after write end
    parameter int T_WC_NS    = 55   // write cycle
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    inout  wire  [DATA_W-1:0] sram_dq
);
    localparam int RD_LEN  = at_least_one(imax(imax(ns_to_cyc(T_AA_NS, T_CLK_NS),
                                                    ns_to_cyc(T_RC_NS, T_CLK_NS)),
                                               ns_to_cyc(T_DOE_NS, T_CLK_NS)));
    localparam int GAP_LEN = at_least_one(ns_to_cyc(T_HZOE_NS, T_CLK_NS));
    localparam int WR_LEN  = at_least_one(imax(imax(ns_to_cyc(T_PWE_NS, T_CLK_NS),
                                                    ns_to_cyc(T_AW_NS, T_CLK_NS)),
                                               imax(ns_to_cyc(T_SCE_NS, T_CLK_NS),
                                                    ns_to_cyc(T_SD_NS, T_CLK_NS))));
    localparam int REC_LEN = at_least_one(imax(ns_to_cyc(T_WC_NS, T_CLK_NS) - WR_LEN,
                                               ns_to_cyc(T_HD_NS, T_CLK_NS)));

    logic              accept, cap_rd, dq_oe;
    logic [DATA_W-1:0] wdata_q;

    sram_ctrl_fsm #(
        .RD_LEN  (RD_LEN),
        .GAP_LEN (GAP_LEN),
        .WR_LEN  (WR_LEN),
        .REC_LEN (REC_LEN)
    ) fsm_i (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .accept    (accept),
        .ready     (req_ready),
        .cap_rd    (cap_rd),
        .done      (done),
        .ce_n      (sram_ce_n),
        .we_n      (sram_we_n),
        .oe_n      (sram_oe_n),
        .dq_oe     (dq_oe)
    );

    sram_ctrl_io #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) io_i (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .cap_rd    (cap_rd),
        .dq_in     (sram_dq),
        .addr_q    (sram_addr),
        .wdata_q   (wdata_q),
        .rd_data   (rd_data)
    );

    assign sram_dq = dq_oe ? wdata_q : {DATA_W{1'bz}};

    // R5: bus driven only inside a write strobe window
    a_r5_drive_in_write: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> (!sram_we_n && !sram_ce_n && sram_oe_n));

    // R3: write strobe only with select low and outputs disabled
    a_r3_write_strobes: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |-> (!sram_ce_n && sram_oe_n));

    // R4: read strobe only with select low and write high
    a_r4_read_strobes: assert property (@(posedge clk) disable iff (rst)
        !sram_oe_n |-> (!sram_ce_n && sram_we_n));

    // R6: no write strobe in the cycle output enable is released
    a_r6_turnaround: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_oe_n) |-> sram_we_n);

    // R3: address frozen while the memory is selected
    a_r3_addr_stable: assert property (@(posedge clk) disable iff (rst)
        (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));

endmodule

// File: tb/sram_async_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_async_ctrl_tb_top;
    localparam int TCLK   = 10;
    localparam int T_AA   = 55;
    localparam int T_HZ   = 20;
    localparam int WR_MIN = 45;  // max of pulse 40, addr-to-end 45, select-to-end 45, setup 25
    localparam int RD_MIN = 55;
    localparam int EXP_RD_LAT = (T_AA + TCLK - 1) / TCLK + (T_HZ + TCLK - 1) / TCLK + 1;
    localparam int EXP_WR_LAT = (WR_MIN + TCLK - 1) / TCLK + 1 + 1;
    localparam int NV = 10;
    // {write, addr[14:0], data[7:0]}
    localparam logic [23:0] VEC [NV] = '{
        {1'b1, 15'h0000, 8'hA5}, {1'b1, 15'h7FFF, 8'h3C},
        {1'b0, 15'h0000, 8'h00}, {1'b0, 15'h7FFF, 8'h00},
        {1'b1, 15'h1234, 8'h01}, {1'b1, 15'h1234, 8'hFE},
        {1'b0, 15'h1234, 8'h00}, {1'b0, 15'h0042, 8'h00},
        {1'b1, 15'h4000, 8'h80}, {1'b0, 15'h4000, 8'h00}
    };

    logic        clk = 1'b0, rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, done;
    logic [7:0]  rd_data;
    logic [14:0] sram_addr;
    logic        sram_ce_n, sram_we_n, sram_oe_n;
    wire  [7:0]  sram_dq;

    int checks = 0, failures = 0, done_cnt = 0;
    logic finished = 1'b0;

    always #(TCLK/2) clk = ~clk;

    sram_async_ctrl dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .done(done), .rd_data(rd_data), .sram_addr(sram_addr),
        .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
        .sram_dq(sram_dq)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // ---------------- memory model ----------------
    logic [7:0] mem [int];
    logic [7:0] shadow [int];
    logic [7:0] mdl_out = 8'hEE;
    logic       hz_hold = 1'b0;
    logic       rd_act;
    assign rd_act  = !sram_ce_n && !sram_oe_n && sram_we_n;
    assign sram_dq = (rd_act || hz_hold) ? mdl_out : 8'bz;

    function automatic logic [7:0] mem_rd(input int a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    function automatic logic [7:0] sh_rd(input int a);
        return shadow.exists(a) ? shadow[a] : 8'h00;
    endfunction

    always begin
        @(rd_act or sram_addr);
        mdl_out = 8'hEE;
        if (rd_act) begin
            #(T_AA);
            if (rd_act) mdl_out = mem_rd(int'(sram_addr));
        end
    end

    always @(negedge rd_act) begin
        hz_hold = 1'b1;
        #(T_HZ);
        hz_hold = 1'b0;
    end

    int          wr_cnt = 0, rd_cnt = 0;
    logic [7:0]  wr_dq;
    logic [14:0] wr_a;
    logic        done_prev = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (!sram_ce_n && !sram_we_n) begin
                if (wr_cnt > 0) begin
                    chk(sram_dq == wr_dq, "R3 data stable", sram_dq, wr_dq);
                    chk(sram_addr == wr_a, "R3 addr stable", sram_addr, wr_a);
                end
                chk(sram_oe_n, "R3 oe high in write", sram_oe_n, 1);
                wr_dq = sram_dq;
                wr_a  = sram_addr;
                wr_cnt++;
            end else if (wr_cnt > 0) begin
                chk(wr_cnt * TCLK >= WR_MIN, "R3 write width", wr_cnt * TCLK, WR_MIN);
                mem[int'(wr_a)] = wr_dq;
                wr_cnt = 0;
            end
            if (rd_act) rd_cnt++;
            else if (rd_cnt > 0) begin
                chk(rd_cnt * TCLK >= RD_MIN, "R4 read width", rd_cnt * TCLK, RD_MIN);
                rd_cnt = 0;
            end
            if (hz_hold && !sram_we_n) chk(1'b0, "R6 bus conflict", 1, 0);
            if (done) begin
                done_cnt++;
                chk(!done_prev, "R7 done single", 1, 0);
            end
            done_prev = done;
        end
    end

    // ---------------- request driver ----------------
    task automatic access(input logic wr, input logic [14:0] a, input logic [7:0] d,
                          output int lat);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        if (wr) shadow[int'(a)] = d;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int lat;
        logic [7:0] held;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(sram_ce_n && sram_we_n && sram_oe_n, "R1 strobes in reset",
            {sram_ce_n, sram_we_n, sram_oe_n}, 3'b111);
        chk(req_ready && !done, "R1 ready/done in reset", {req_ready, done}, 2'b10);
        chk(rd_data == 8'h00, "R1 rd_data in reset", rd_data, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(sram_ce_n && sram_we_n && sram_oe_n && req_ready, "R1 idle after reset",
            {sram_ce_n, sram_we_n, sram_oe_n, req_ready}, 4'hF);

        // vector walk (back-to-back: next request driven in the done cycle)
        for (int i = 0; i < NV; i++) begin
            held = rd_data;
            access(VEC[i][23], VEC[i][22:8], VEC[i][7:0], lat);
            if (VEC[i][23]) begin
                chk(lat == EXP_WR_LAT, "R7 write latency", lat, EXP_WR_LAT);
                chk(rd_data == held, "R8 rd_data held over write", rd_data, held);
            end else begin
                chk(lat == EXP_RD_LAT, "R7 read latency", lat, EXP_RD_LAT);
                chk(rd_data == sh_rd(int'(VEC[i][22:8])), "R4 read data (R5 no fight)",
                    rd_data, sh_rd(int'(VEC[i][22:8])));
            end
        end

        // R2: request while busy is ignored
        @(negedge clk);
        done_cnt = 0;
        req_valid = 1'b1; req_write = 1'b1; req_addr = 15'h0100; req_wdata = 8'h77;
        @(negedge clk);
        req_addr = 15'h0200; req_wdata = 8'h99;   // busy now: must be ignored
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
        repeat (6) @(negedge clk);
        shadow[32'h100] = 8'h77;
        chk(done_cnt == 1, "R2 single done for busy request", done_cnt, 1);
        access(1'b0, 15'h0200, 8'h00, lat);
        chk(rd_data == 8'h00, "R2 ignored write left memory", rd_data, 0);
        access(1'b0, 15'h0100, 8'h00, lat);
        chk(rd_data == 8'h77, "R3 accepted write landed", rd_data, 8'h77);

        // R6: read immediately followed by write
        access(1'b0, 15'h7FFF, 8'h00, lat);
        access(1'b1, 15'h7FFE, 8'h5A, lat);
        access(1'b0, 15'h7FFE, 8'h00, lat);
        chk(rd_data == 8'h5A, "R6 write after read", rd_data, 8'h5A);

        repeat (4) @(negedge clk);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule